// File: doc/BRIEF.md
# Latched Parallel-In Serial-Out Shifter

This block serializes a parallel word through two storage stages. A holding latch captures the parallel bus on a rising edge of a capture strobe. A shift register of the same width takes the latch contents whenever the mode input selects loading. When the mode input selects shifting, the shift register moves one place toward its last stage on each rising edge of a shift strobe. A new bit enters the first stage from a serial input. The only output is the last stage of the shift register.

Everything runs on one system clock. Both strobes, the mode input and the active-low shift-register clear are sampled through a synchronizer chain of `SYNC_STAGES` flops. Each strobe is then edge-detected, so a strobe held high acts once. The parallel bus and the serial input are sampled directly when the detected edge is acted on. A source must therefore hold them steady until that point. A system reset brings both the latch and the shift register to zero. The shift-register clear input empties only the shift register.

Top module: `piso_latched`

## Requirements
- R1: A rising edge on `cap_strobe` copies `par_in` into the holding latch, in either mode and while the clear is active.
- R2: While `sr_clr_n` is low, every shift-register stage is 0, so `ser_out` is 0. The holding latch keeps its value.
- R3: While `shf_mode` is 0 (load) and the clear is inactive, the shift register follows the latch contents, and shift-strobe edges have no effect.
- R4: While `shf_mode` is 1 (shift), each rising `shf_strobe` edge puts `ser_in` into stage 0 (bit 0) and moves stage i to stage i+1. The old top stage is dropped.
- R5: `ser_in` has no effect while `shf_mode` is 0.
- R6: `ser_out` is always the top stage (bit WIDTH-1) of the shift register.
- R7: A capture edge in load mode puts the new word into both the latch and the shift register, so `ser_out` becomes `par_in[WIDTH-1]`.
- R8: A capture edge and a shift edge in the same cycle in shift mode do two things: the latch takes the new word, and the shift register shifts its old contents.
- R9: With no strobe edge, shift mode selected and the clear inactive, the latch and the shift register hold their contents.
- R10: For the shift register, the clear wins over loading, and loading wins over shifting. The latch still captures during the clear.
- R11: A change on a strobe, mode or clear pin takes effect at the third rising system-clock edge after the pin changes, with SYNC_STAGES = 2. A strobe held high counts as one edge.
- R12: After `rst_n` is asserted, the latch and the shift register are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| par_in | input | WIDTH | Parallel data into the holding latch |
| ser_in | input | 1 | Serial data into stage 0 |
| cap_strobe | input | 1 | Latch capture strobe; its rising edge is used |
| shf_strobe | input | 1 | Shift strobe; its rising edge is used |
| shf_mode | input | 1 | 1 = shift, 0 = load from the latch (level) |
| sr_clr_n | input | 1 | Active-low shift-register clear (level) |
| ser_out | output | 1 | Top stage of the shift register |

## Verification
The bench sweeps all 256 words through capture, load and readout, each followed by eight shifts of a second computed pattern. It then toggles the serial input and the shift strobe during load mode; a design that leaked them would change `ser_out` away from the latch's top bit. It captures a word and shifts in the same cycle; a design that shifted the newly captured word, or dropped the capture, would read back the wrong bits. It also checks that the latch survives the clear and that the clear beats loading. It checks the exact three-cycle latency, and that a strobe held high acts once; a level-triggered shifter would run all the bits out.

// File: rtl/piso_latched.sv
module piso_latched #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] par_in,
  input  logic             ser_in,
  input  logic             cap_strobe,
  input  logic             shf_strobe,
  input  logic             shf_mode,
  input  logic             sr_clr_n,
  output logic             ser_out
);
  localparam int TOP  = WIDTH - 1;
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0]  cap_sy, shf_sy, mode_sy, clr_sy;
  logic           cap_prev, shf_prev;
  logic [TOP:0]   latch_q, sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_sy   <= '1;
      shf_sy   <= '1;
      mode_sy  <= '1;
      clr_sy   <= '1;
      cap_prev <= 1'b1;
      shf_prev <= 1'b1;
    end else begin
      cap_sy   <= {cap_sy[LAST-1:0],  cap_strobe};
      shf_sy   <= {shf_sy[LAST-1:0],  shf_strobe};
      mode_sy  <= {mode_sy[LAST-1:0], shf_mode};
      clr_sy   <= {clr_sy[LAST-1:0],  sr_clr_n};
      cap_prev <= cap_sy[LAST];
      shf_prev <= shf_sy[LAST];
    end
  end

  wire cap_rise = cap_sy[LAST] & ~cap_prev;
  wire shf_rise = shf_sy[LAST] & ~shf_prev;
  wire mode_now = mode_sy[LAST];
  wire clr_now  = clr_sy[LAST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        latch_q <= '0;
    else if (cap_rise) latch_q <= par_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sr <= '0;
    else if (!clr_now)  sr <= '0;
    else if (!mode_now) sr <= cap_rise ? par_in : latch_q;
    else if (shf_rise)  sr <= {sr[TOP-1:0], ser_in};
  end

  assign ser_out = sr[TOP];

  assert_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cap_rise |=> latch_q == $past(par_in));
  assert_clear_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_now |=> !ser_out);
  assert_latch_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_now && !cap_rise) |=> $stable(latch_q));
  assert_follow_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_now && !mode_now && !cap_rise) |=> sr == $past(latch_q));
  assert_shift_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_now && mode_now && shf_rise) |=> ser_out == $past(sr[TOP-1]));
  assert_load_through_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_now && !mode_now && cap_rise) |=> ser_out == $past(par_in[TOP]));
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_now && mode_now && !shf_rise) |=> $stable(sr));
endmodule

// File: tb/sim_piso_latched.sv
module sim_piso_latched;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] par_in = '0;
  logic ser_in = 1'b0, cap_strobe = 1'b0, shf_strobe = 1'b0;
  logic shf_mode = 1'b1, sr_clr_n = 1'b1;
  logic ser_out;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [7:0] exp_sr = '0, exp_lat = '0;
  bit m_mode = 1'b1, m_clr = 1'b1;

  always #5 clk = ~clk;

  piso_latched #(.WIDTH(8), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .par_in(par_in), .ser_in(ser_in),
    .cap_strobe(cap_strobe), .shf_strobe(shf_strobe), .shf_mode(shf_mode),
    .sr_clr_n(sr_clr_n), .ser_out(ser_out));

  task automatic check(string tag, logic expv);
    n_chk++;
    if (ser_out !== expv) begin
      n_bad++;
      $display("FAIL %s: ser_out=%0b expected %0b", tag, ser_out, expv);
    end
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic void model_level();
    if (!m_clr) exp_sr = '0;
    else if (!m_mode) exp_sr = exp_lat;
  endfunction

  task automatic set_mode(bit m, string tag);
    shf_mode = m; m_mode = m;
    settle(); model_level(); check(tag, exp_sr[7]);
  endtask

  task automatic set_clr(bit c, string tag);
    sr_clr_n = c; m_clr = c;
    settle(); model_level(); check(tag, exp_sr[7]);
  endtask

  task automatic cap_pulse(logic [7:0] d, string tag);
    par_in = d; cap_strobe = 1'b1;
    settle();
    exp_lat = d; model_level(); check(tag, exp_sr[7]);
    cap_strobe = 1'b0; settle(); check(tag, exp_sr[7]);
  endtask

  task automatic shf_pulse(bit b, string tag);
    ser_in = b; shf_strobe = 1'b1;
    settle();
    if (m_clr && m_mode) exp_sr = {exp_sr[6:0], b};
    model_level(); check(tag, exp_sr[7]);
    shf_strobe = 1'b0; ser_in = ~b; settle(); check(tag, exp_sr[7]);
  endtask

  task automatic both_pulse(logic [7:0] d, bit b, string tag);
    par_in = d; ser_in = b; cap_strobe = 1'b1; shf_strobe = 1'b1;
    settle();
    if (m_clr && m_mode) exp_sr = {exp_sr[6:0], b};
    exp_lat = d; model_level(); check(tag, exp_sr[7]);
    cap_strobe = 1'b0; shf_strobe = 1'b0; settle(); check(tag, exp_sr[7]);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    settle(); check("R12 reset output", 1'b0);
    set_mode(1'b0, "R12 latch zero after reset");
    set_mode(1'b1, "R12");

    for (int v = 0; v < 256; v++) begin
      logic [7:0] pat;
      pat = 8'((v * 37 + 11) & 8'hFF);
      cap_pulse(8'(v), "R1 capture in shift mode");
      set_mode(1'b0, "R3 load from latch");
      shf_pulse(1'b1, "R5 shift ignored in load mode");
      shf_pulse(1'b0, "R3 shift strobe no effect");
      set_mode(1'b1, "R9 back to shift");
      for (int i = 0; i < 8; i++) shf_pulse(pat[7-i], "R4 R6 readout");
      both_pulse(~8'(v), pat[0], "R8 capture with shift");
      for (int i = 0; i < 7; i++) shf_pulse(1'b0, "R4 shifted pattern");
      set_mode(1'b0, "R8 latch took new word");
      cap_pulse(pat, "R7 capture in load mode");
      set_mode(1'b1, "R6");
    end

    repeat (20) @(posedge clk);
    @(negedge clk); check("R9 idle hold", exp_sr[7]);

    cap_pulse(8'hA5, "R1");
    set_clr(1'b0, "R2 clear empties register");
    set_mode(1'b0, "R10 clear beats load");
    cap_pulse(8'h3C, "R10 capture during clear");
    shf_pulse(1'b1, "R10 clear beats shift");
    set_clr(1'b1, "R2 latch kept through clear");
    set_mode(1'b1, "R2");
    for (int i = 0; i < 8; i++) shf_pulse(1'b0, "R2 R10 latch contents");

    set_mode(1'b0, "R11 setup");
    par_in = 8'h80; cap_strobe = 1'b1;
    repeat (2) @(posedge clk); @(negedge clk);
    check("R11 not yet after two edges", 1'b0);
    @(posedge clk); @(negedge clk);
    check("R11 effect at third edge", 1'b1);
    exp_lat = 8'h80; exp_sr = 8'h80;
    cap_strobe = 1'b0; settle();
    set_mode(1'b1, "R11");
    ser_in = 1'b1; shf_strobe = 1'b1;
    repeat (20) @(posedge clk); @(negedge clk);
    exp_sr = {exp_sr[6:0], 1'b1};
    check("R11 held strobe shifts once", exp_sr[7]);
    shf_strobe = 1'b0; settle();
    shf_pulse(1'b0, "R11 one shift only");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule